// File: doc/BRIEF.md
# Node Address to System Address Rebuilder

This block turns an address local to one memory node back into the system-wide physical address it came from. A node address has had its node-interleave bits removed. The block first puts those bits back to form the node's DRAM address. It then maps that DRAM address to a system address, using either the relocated memory-hole window or the node's DRAM base. The result is sign-extended from bit 39, so a system address built from the base is always a canonical 64-bit value.

Each request is a single address presented with a valid/ready handshake. The interleave code, the node's select value, the node base and the hole window are all configuration inputs. They are sampled in the cycle a request is accepted. Both the rebuilt DRAM address and the system address are returned together through a registered output stage. That stage has one cycle of latency and holds its result while the consumer stalls.

Top module: `dram_sys_addr_rebuild`

## Requirements
- R1: The interleave shift count comes from the 3-bit interleave code as follows: code 1 gives 1, code 3 gives 2, code 7 gives 3, and every other code gives 0.
- R2: When the shift count is 0, the DRAM address equals the whole 64-bit input address, unchanged.
- R3: When the shift count s is nonzero, input bits 35:12 move up by s places, input bits 11:0 stay at bits 11:0, and the low s bits of the select value are placed at bit 12 and upward. Input bits 63:36 have no effect.
- R4: When the hole is enabled and the DRAM address is at least the hole base and below the hole base plus the hole size, the system address is the DRAM address plus the hole offset. All 64 bits are kept and no sign extension is applied.
- R5: In every other case the system address is bits 39:0 of the DRAM address plus the node base, and bits 63:40 are copies of bit 39. This covers a disabled hole and a DRAM address exactly equal to the hole base plus the hole size.
- R6: During reset the output is not valid and the input is ready.
- R7: A request accepted in one cycle (in_valid and in_ready high at a clock edge) is presented with out_valid high from the next edge on.
- R8: While out_valid is high and out_ready is low, the output data stays stable. in_ready is high exactly when the output stage is empty or is being drained. Results leave in the order their requests were accepted, with none lost or repeated.
- R9: Take a canonical system address, either outside the hole or inside the relocated region starting at 2^32. Convert it forward to a node address with matching select bits, then pass it through this block. The block returns the original system address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_intlv_code | input | 3 | Interleave enable code |
| cfg_intlv_sel | input | 3 | This node's interleave select value |
| cfg_node_base | input | 40 | Node DRAM base in system space |
| cfg_hole_en | input | 1 | Hole relocation enabled |
| cfg_hole_base | input | 64 | First DRAM address of the hole window |
| cfg_hole_offset | input | 64 | Amount added to hole-window DRAM addresses |
| cfg_hole_size | input | 64 | Size of the hole window |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_addr | input | 64 | Node input address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes result |
| out_dram | output | 64 | Rebuilt DRAM address |
| out_sys | output | 64 | Rebuilt system address |

## Verification
Two things can happen in the same cycle: a stalled result is drained, and a new request is captured into the same register. The bench provokes this in two ways. Some passes hold in_valid high back to back while out_ready follows a repeating three-of-five pattern. Other passes keep out_ready high throughout. The results are judged against an in-order queue of expected values computed arithmetically in the bench, so any loss, duplication or overwrite of a held result shows up as a mismatch. Each cycle of a stall is also checked for stable output data.

// File: rtl/addr_rebuild_pkg.sv
package addr_rebuild_pkg;
  localparam int ADDR_W  = 64;  // system address width
  localparam int PHYS_W  = 40;  // implemented physical bits, sign bit is PHYS_W-1
  localparam int PAGE_W  = 12;  // bits never touched by interleaving
  localparam int NODE_HI = 36;  // node input address field is [NODE_HI-1:PAGE_W]
  localparam int CODE_W  = 3;
  localparam int SEL_W   = 3;
  localparam int SHIFT_W = 2;

  // interleave code to number of removed node bits
  function automatic logic [SHIFT_W-1:0] shift_of_code(input logic [CODE_W-1:0] code);
    case (code)
      CODE_W'(1): return SHIFT_W'(1);
      CODE_W'(3): return SHIFT_W'(2);
      CODE_W'(7): return SHIFT_W'(3);
      default:    return SHIFT_W'(0);
    endcase
  endfunction

  // put the select bits back at PAGE_W, moving the node field up
  function automatic logic [ADDR_W-1:0] reinsert_sel(input logic [ADDR_W-1:0] a,
                                                     input logic [SHIFT_W-1:0] s,
                                                     input logic [SEL_W-1:0] sel);
    logic [ADDR_W-1:0] field_msk, low_msk, mid, low, ins;
    logic [SEL_W-1:0]  sel_msk;
    if (s == '0) return a;
    low_msk   = (ADDR_W'(1) << PAGE_W) - ADDR_W'(1);
    field_msk = ((ADDR_W'(1) << NODE_HI) - ADDR_W'(1)) & ~low_msk;
    mid       = (a & field_msk) << s;
    low       = a & low_msk;
    sel_msk   = SEL_W'((1 << s) - 1);
    ins       = ADDR_W'(sel & sel_msk) << PAGE_W;
    return mid + low + ins;
  endfunction

  // truncate to the implemented width and replicate its top bit
  function automatic logic [ADDR_W-1:0] canonical(input logic [ADDR_W-1:0] v);
    logic [PHYS_W-1:0] t;
    t = v[PHYS_W-1:0];
    return {{(ADDR_W-PHYS_W){t[PHYS_W-1]}}, t};
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] x,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [ADDR_W-1:0] size);
    return (x >= base) && (x < base + size);
  endfunction
endpackage

// File: rtl/intlv_restore.sv
module intlv_restore
  import addr_rebuild_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int CW = CODE_W,
  parameter int SW = SEL_W
) (
  input  logic [AW-1:0]      node_addr,
  input  logic [CW-1:0]      code,
  input  logic [SW-1:0]      sel,
  output logic [SHIFT_W-1:0] shift_cnt,
  output logic [AW-1:0]      dram_addr
);
  always_comb begin
    shift_cnt = shift_of_code(code);
    dram_addr = reinsert_sel(node_addr, shift_cnt, sel);
  end
endmodule

// File: rtl/sys_map.sv
module sys_map
  import addr_rebuild_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PHYS_W
) (
  input  logic [AW-1:0] dram_addr,
  input  logic [PW-1:0] node_base,
  input  logic          hole_en,
  input  logic [AW-1:0] hole_base,
  input  logic [AW-1:0] hole_offset,
  input  logic [AW-1:0] hole_size,
  output logic          hole_hit,
  output logic [AW-1:0] sys_addr
);
  logic [AW-1:0] base_sum;

  always_comb begin
    hole_hit = hole_en && in_window(dram_addr, hole_base, hole_size);
    base_sum = dram_addr + AW'(node_base);
    sys_addr = hole_hit ? (dram_addr + hole_offset) : canonical(base_sum);
  end
endmodule

// File: rtl/rebuild_out_stage.sv
module rebuild_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/dram_sys_addr_rebuild.sv
module dram_sys_addr_rebuild
  import addr_rebuild_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PHYS_W,
  parameter int CW = CODE_W,
  parameter int SW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_intlv_code,
  input  logic [SW-1:0] cfg_intlv_sel,
  input  logic [PW-1:0] cfg_node_base,
  input  logic          cfg_hole_en,
  input  logic [AW-1:0] cfg_hole_base,
  input  logic [AW-1:0] cfg_hole_offset,
  input  logic [AW-1:0] cfg_hole_size,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_dram,
  output logic [AW-1:0] out_sys
);
  localparam int DW = 2 * AW + 1;

  logic [SHIFT_W-1:0] shift_cnt;
  logic [AW-1:0]      dram_c, sys_c;
  logic               hole_c, hole_q;
  logic [DW-1:0]      stage_q;
  logic               accept;

  assign accept = in_valid && in_ready;

  intlv_restore #(.AW(AW), .CW(CW), .SW(SW)) i_restore (
    .node_addr (in_addr),
    .code      (cfg_intlv_code),
    .sel       (cfg_intlv_sel),
    .shift_cnt (shift_cnt),
    .dram_addr (dram_c)
  );

  sys_map #(.AW(AW), .PW(PW)) i_map (
    .dram_addr   (dram_c),
    .node_base   (cfg_node_base),
    .hole_en     (cfg_hole_en),
    .hole_base   (cfg_hole_base),
    .hole_offset (cfg_hole_offset),
    .hole_size   (cfg_hole_size),
    .hole_hit    (hole_c),
    .sys_addr    (sys_c)
  );

  rebuild_out_stage #(.W(DW)) i_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({hole_c, dram_c, sys_c}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_q)
  );

  assign hole_q   = stage_q[DW-1];
  assign out_dram = stage_q[2*AW-1:AW];
  assign out_sys  = stage_q[AW-1:0];

  // R7: accepted request shows up after exactly one edge
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R8: a stalled result is held unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dram) && $stable(out_sys)));

  // R3: the page offset passes through whatever the shift
  a_r3_page_offset: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (out_dram[PAGE_W-1:0] == $past(in_addr[PAGE_W-1:0])));

  // R2: zero shift leaves the address untouched
  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && shift_cnt == '0) |=> (out_dram == $past(in_addr)));

  // R5: base-path results are canonical
  a_r5_canonical: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !hole_q) |-> ((&out_sys[AW-1:PW-1]) || !(|out_sys[AW-1:PW-1])));
endmodule

// File: tb/test_dram_sys_addr_rebuild.sv
module test_dram_sys_addr_rebuild;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_intlv_code = '0;
  logic [2:0]  cfg_intlv_sel = '0;
  logic [39:0] cfg_node_base = '0;
  logic        cfg_hole_en = 1'b0;
  logic [63:0] cfg_hole_base = '0;
  logic [63:0] cfg_hole_offset = '0;
  logic [63:0] cfg_hole_size = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_dram, out_sys;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall = 1'b0;
  bit done = 1'b0;

  logic [63:0] q_dram[$];
  logic [63:0] q_sys[$];
  string       q_dtag[$];
  string       q_stag[$];

  bit          hv = 1'b0;
  logic [63:0] hd, hs;

  always #4 clk = ~clk;  // 125 MHz

  dram_sys_addr_rebuild i_dram_sys_addr_rebuild (
    .clk(clk), .rst_n(rst_n),
    .cfg_intlv_code(cfg_intlv_code), .cfg_intlv_sel(cfg_intlv_sel),
    .cfg_node_base(cfg_node_base), .cfg_hole_en(cfg_hole_en),
    .cfg_hole_base(cfg_hole_base), .cfg_hole_offset(cfg_hole_offset),
    .cfg_hole_size(cfg_hole_size),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_dram(out_dram), .out_sys(out_sys)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---- reference arithmetic ----
  function automatic int nbits(input logic [2:0] c);
    if (c == 3'd7) return 3;
    if (c == 3'd3) return 2;
    if (c == 3'd1) return 1;
    return 0;
  endfunction

  function automatic logic [63:0] exp_dram(input logic [63:0] a, input logic [2:0] c, input logic [2:0] sel);
    logic [63:0] p;
    int s = nbits(c);
    if (s == 0) return a;
    p = 64'd1 << s;
    return ((a / 64'd4096) % (64'd1 << 24)) * p * 64'd4096 + (64'(sel) % p) * 64'd4096 + a % 64'd4096;
  endfunction

  function automatic logic [63:0] canon_b(input logic [63:0] x);
    logic [63:0] v = x % (64'd1 << 40);
    if (v >= (64'd1 << 39)) return v - (64'd1 << 40);
    return v;
  endfunction

  function automatic bit hole_b(input logic [63:0] d);
    return cfg_hole_en && (d >= cfg_hole_base) && (d - cfg_hole_base < cfg_hole_size);
  endfunction

  function automatic logic [63:0] exp_sys(input logic [63:0] d);
    if (hole_b(d)) return d + cfg_hole_offset;
    return canon_b(d + 64'(cfg_node_base));
  endfunction

  // forward direction, used only for the round trip
  function automatic logic [63:0] fwd_dram(input logic [63:0] s);
    if (cfg_hole_en && s >= (64'd1 << 32) && s - (64'd1 << 32) < cfg_hole_size)
      return s - cfg_hole_offset;
    return (s % (64'd1 << 40)) - 64'(cfg_node_base);
  endfunction

  function automatic logic [63:0] fwd_input(input logic [63:0] d, input logic [2:0] c);
    int s = nbits(c);
    return ((d >> s) & 64'h0000_000F_FFFF_F000) + (d & 64'hFFF);
  endfunction

  // ---- stimulus ----
  task automatic push(input logic [63:0] a, input logic [63:0] ed, input logic [63:0] es,
                      input string dtag, input string stag);
    @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q_dram.push_back(ed);
    q_sys.push_back(es);
    q_dtag.push_back(dtag);
    q_stag.push_back(stag);
    @(posedge clk);
    #1;
  endtask

  task automatic idle_drain();
    @(negedge clk);
    in_valid = 1'b0;
    while (q_dram.size() != 0) @(negedge clk);
  endtask

  task automatic send(input logic [63:0] a, input string stag_in);
    logic [63:0] d = exp_dram(a, cfg_intlv_code, cfg_intlv_sel);
    string dt = (nbits(cfg_intlv_code) == 0) ? "R1 R2" : "R1 R3";
    string st = stag_in;
    if (st == "") st = hole_b(d) ? "R4" : "R5";
    push(a, d, exp_sys(d), dt, st);
  endtask

  // ---- monitor: sets out_ready, then judges what leaves at the next edge ----
  always @(negedge clk) begin
    cyc++;
    out_ready = stall ? ((cyc % 5) < 3) : 1'b1;
    if (rst_n) begin
      if (hv) chk(out_valid && out_dram == hd && out_sys == hs, "R8 hold", out_sys, hs);
      if (out_valid && out_ready) begin
        if (q_dram.size() == 0) chk(1'b0, "R8 extra output", out_sys, 64'd0);
        else begin
          chk(out_dram == q_dram[0], q_dtag[0], out_dram, q_dram[0]);
          chk(out_sys == q_sys[0], q_stag[0], out_sys, q_sys[0]);
          void'(q_dram.pop_front());
          void'(q_sys.pop_front());
          void'(q_dtag.pop_front());
          void'(q_stag.pop_front());
        end
      end
      hv = out_valid && !out_ready;
      hd = out_dram;
      hs = out_sys;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] sys_list[6];
    logic [39:0] base_list[6];
    logic [2:0]  codes[4];
    codes = '{3'd0, 3'd1, 3'd3, 3'd7};

    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R6 out_valid", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R6 in_ready", 64'(in_ready), 64'd1);
    rst_n = 1'b1;

    cfg_node_base   = 40'h12_3400_0000;
    cfg_hole_base   = 64'hC000_0000;
    cfg_hole_size   = 64'h4000_0000;
    cfg_hole_offset = 64'h4000_0000;

    // R7: single request into an empty stage
    cfg_hole_en = 1'b1;
    push(64'h0000_0001_2345_6789, exp_dram(64'h0000_0001_2345_6789, 3'd0, 3'd0),
         exp_sys(64'h0000_0001_2345_6789), "R1 R2", "R5");
    chk(out_valid == 1'b1, "R7 latency", 64'(out_valid), 64'd1);
    idle_drain();

    // sweep every code and select, back to back, stalled on odd codes
    for (int c = 0; c < 8; c++) begin
      for (int sl = 0; sl < 8; sl++) begin
        idle_drain();
        cfg_intlv_code = 3'(c);
        cfg_intlv_sel  = 3'(sl);
        stall = c[0];
        for (int k = 0; k < 6; k++) begin
          logic [63:0] a;
          if (k < 3) a = (64'(k + 1) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(c * 8 + sl) << 20);
          else       a = 64'hC000_0000 + 64'(k) * 64'h0123_4567 + 64'(sl);
          send(a, "");
        end
      end
    end
    idle_drain();
    stall = 1'b0;

    // hole boundaries with zero shift
    cfg_intlv_code = 3'd0;
    send(64'hC000_0000, "R4 low edge");
    send(64'hFFFF_FFFF, "R4 high edge");
    send(64'h1_0000_0000, "R5 end of window");
    send(64'hBFFF_FFFF, "R5 below window");
    send(64'h0000_0080_0000_0000 - 64'h12_3400_0000, "R5 sign bit");
    idle_drain();
    cfg_hole_en = 1'b0;
    send(64'hC000_0000, "R5 hole disabled");
    send(64'hD234_5678, "R5 hole disabled");
    idle_drain();
    cfg_hole_en = 1'b1;

    // R9 round trip
    sys_list  = '{64'h0000_0020_1234_5ABC, 64'hFFFF_FF80_0ABC_D123, 64'h0000_0020_0000_0FFF,
                  64'h0000_0001_0000_0000, 64'h0000_0001_2345_6789, 64'h0000_0001_3FFF_FFFF};
    base_list = '{40'h20_0000_0000, 40'h80_0000_0000, 40'h20_0000_0000,
                  40'h20_0000_0000, 40'h20_0000_0000, 40'h20_0000_0000};
    stall = 1'b1;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 4; j++) begin
        logic [63:0] d;
        int s;
        idle_drain();
        cfg_node_base  = base_list[i];
        cfg_intlv_code = codes[j];
        d = fwd_dram(sys_list[i]);
        s = nbits(codes[j]);
        cfg_intlv_sel  = 3'((d >> 12) % (64'd1 << s));
        push(fwd_input(d, codes[j]), d, sys_list[i], "R9 dram", "R9 system");
      end
    end
    idle_drain();
    stall = 1'b0;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule